// File: doc/BRIEF.md
# Host Memory Address Router

This block decides, for every host memory access, whether main memory (DRAM) or the PCI bus serves it. It also reports whether the result may be cached and whether the access lands in System Management RAM. The address decode is purely combinational. The settings that shape the decode sit in a small bank of registers. These registers load as a group when `cfg_load` is high at a rising clock edge, so the outputs always reflect the last committed configuration.

The decode uses four pieces of configuration:
- a top-of-memory value in megabytes, held below a build-time ceiling;
- an optional PCI window, called the gap, placed inside the 1 MB to 16 MB region;
- an enable for SMRAM;
- a placement select for SMRAM.

SMRAM can sit in the last 64 KB under the top of memory, or in one of the two legacy 64 KB segments at 0xA0000 and 0xB0000. Only the processor reaches SMRAM. Masters on the PCI side that touch a legacy segment holding SMRAM are sent to PCI. The outputs are control levels, not a data stream, so there is no handshake. The low 16 address bits never affect any output.

Top module: `host_mem_router`

## Requirements
- R1: After reset the configuration is: top of memory 2 MB, gap off, SMRAM off. Address 0x001FFFFF routes to DRAM and 0x00200000 routes to PCI.
- R2: For every address, exactly one of `route_dram` and `route_pci` is high.
- R3: Outside the legacy segments and the gap, an address below top-of-memory × 1 MB routes to DRAM. An address at or above that value routes to PCI.
- R4: A programmed top of memory above `CEIL_MB` (default 192) acts as exactly `CEIL_MB`.
- R5: With the gap enabled, the size code selects the gap size: 0 = 1 MB, 1 = 2 MB, 2 = 4 MB, 3 = 8 MB.
  - The base is a MB index (0–15). Base bits below the size are ignored.
  - Addresses in [base, base+size) that are at or above 1 MB route to PCI, ahead of DRAM routing and ahead of top-of-memory SMRAM.
- R6: `cacheable` is high exactly when the access routes to DRAM.
- R7: With SMRAM enabled and placement code 0 or 3, the last 64 KB below the effective top is SMRAM.
  - A processor access there raises `smram_hit` and routes to DRAM.
  - A PCI-master access there routes to DRAM without `smram_hit`.
- R8: With SMRAM enabled, placement code 1 puts SMRAM at 0xA0000–0xAFFFF and code 2 puts it at 0xB0000–0xBFFFF. A processor access there routes to DRAM with `smram_hit`.
- R9: A PCI-master access to a legacy segment that holds SMRAM routes to PCI with `smram_hit` low.
- R10: Any access to 0xA0000–0xBFFFF that is not a processor SMRAM access routes to PCI. This covers SMRAM off, the other segment, and top placement.
- R11: Configuration inputs have no effect unless `cfg_load` is high at a rising clock edge.
- R12: `smram_hit` is never high while SMRAM is disabled or while the access routes to PCI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Commit all configuration inputs at this edge |
| cfg_top_mb | input | 10 | Installed memory top, in MB |
| cfg_gap_en | input | 1 | Enable the PCI window in 1–16 MB |
| cfg_gap_base | input | 4 | Window base, MB index |
| cfg_gap_size | input | 2 | Window size code (1/2/4/8 MB) |
| cfg_smm_en | input | 1 | Enable SMRAM |
| cfg_smm_place | input | 2 | SMRAM placement: 0/3 top, 1 A segment, 2 B segment |
| acc_addr | input | 32 | Access byte address |
| acc_from_pci | input | 1 | 1 = PCI master, 0 = processor |
| route_dram | output | 1 | Access is served by main memory |
| route_pci | output | 1 | Access is forwarded to PCI |
| cacheable | output | 1 | Access may be cached |
| smram_hit | output | 1 | Processor access to SMRAM |

## Verification
The bench walks every gap base and size against the first and last byte of each megabyte up to 17 MB.
- A window computed with a wrong mask or a missing 1 MB floor would send the low megabyte, or a neighbour megabyte, to the wrong side.
- Each top-of-memory setting, including values past the ceiling, is probed at top−1, at top itself, and at both edges of the 64 KB SMRAM block. An off-by-one in the compare, or a ceiling clamp that is missing, would misroute exactly one of those bytes.
- Each SMRAM placement is probed with both requesters at the legacy segment edges. A design that lets PCI masters reach a relocated SMRAM, or that leaves the unused segment on DRAM, would show up there.
- A gap that covers the top-of-memory SMRAM checks that the gap wins.

// File: rtl/hmr_pkg.sv
package hmr_pkg;
  localparam int ADDR_W    = 32;
  localparam int MB_SHIFT  = 20;
  localparam int SMM_SHIFT = 16;
  localparam int GAP_W     = 4;   // MB index bits covering 0..16 MB
  localparam int TOP_W     = 10;
  localparam int MB_IDX_W  = ADDR_W - MB_SHIFT;
  localparam int BLK_W     = ADDR_W - SMM_SHIFT;

  typedef enum logic [1:0] {
    SMM_AT_TOP     = 2'd0,
    SMM_AT_ASEG    = 2'd1,
    SMM_AT_BSEG    = 2'd2,
    SMM_AT_TOP_ALT = 2'd3
  } smm_place_e;

  typedef struct packed {
    logic [TOP_W-1:0] top_mb;
    logic             gap_en;
    logic [GAP_W-1:0] gap_base;
    logic [1:0]       gap_size;
    logic             smm_en;
    smm_place_e       smm_place;
  } router_cfg_t;
endpackage

// File: rtl/hmr_cfg_regs.sv
module hmr_cfg_regs
  import hmr_pkg::*;
#(
  parameter int CEIL_MB      = 192,
  parameter int RESET_TOP_MB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  router_cfg_t       cfg_in,
  output router_cfg_t       cfg_q,
  output logic [TOP_W-1:0]  top_eff
);
  localparam logic [TOP_W-1:0] CEIL_V  = TOP_W'(CEIL_MB);
  localparam logic [TOP_W-1:0] RESET_V = TOP_W'(RESET_TOP_MB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.top_mb    <= RESET_V;
      cfg_q.gap_en    <= 1'b0;
      cfg_q.gap_base  <= '0;
      cfg_q.gap_size  <= '0;
      cfg_q.smm_en    <= 1'b0;
      cfg_q.smm_place <= SMM_AT_TOP;
    end else if (load) begin
      cfg_q <= cfg_in;
    end
  end

  // Clamp installed memory to the build-time ceiling
  always_comb top_eff = (cfg_q.top_mb > CEIL_V) ? CEIL_V : cfg_q.top_mb;

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));
  assert_top_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    top_eff <= CEIL_V);
endmodule

// File: rtl/hmr_gap_decode.sv
module hmr_gap_decode
  import hmr_pkg::*;
(
  input  logic                gap_en,
  input  logic [GAP_W-1:0]    gap_base,
  input  logic [1:0]          gap_size,
  input  logic [MB_IDX_W-1:0] addr_mb,
  output logic                gap_hit
);
  logic [GAP_W-1:0] low_idx;
  logic [GAP_W-1:0] size_mask;
  logic             under_limit;

  always_comb begin
    low_idx     = addr_mb[GAP_W-1:0];
    under_limit = (addr_mb[MB_IDX_W-1:GAP_W] == '0);
    // size code n -> 2^n MB, base aligned to that size
    size_mask   = ~((GAP_W'(1) << gap_size) - GAP_W'(1));
    gap_hit     = gap_en && under_limit && (low_idx != '0) &&
                  (((low_idx ^ gap_base) & size_mask) == '0);
  end
endmodule

// File: rtl/hmr_smram_decode.sv
module hmr_smram_decode
  import hmr_pkg::*;
(
  input  logic             smm_en,
  input  smm_place_e       smm_place,
  input  logic [TOP_W-1:0] top_eff,
  input  logic [BLK_W-1:0] addr_blk,
  input  logic             from_pci,
  output logic             in_legacy,
  output logic             smm_region,
  output logic             smm_legacy_cpu
);
  localparam int NSEG = 2;
  localparam logic [BLK_W-1:0] SEG0_BLK = BLK_W'(16'h000A);

  logic [NSEG-1:0] seg_match;
  logic [NSEG-1:0] seg_owned;
  logic [BLK_W:0]  top_blk;
  logic            top_place;
  logic            top_match;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_comb begin
      seg_match[g] = (addr_blk == SEG0_BLK + BLK_W'(g));
      seg_owned[g] = smm_en && (smm_place == smm_place_e'(g + 1)) && seg_match[g];
    end
  end

  always_comb begin
    top_blk   = (BLK_W+1)'(top_eff) << (MB_SHIFT - SMM_SHIFT);
    top_place = (smm_place == SMM_AT_TOP) || (smm_place == SMM_AT_TOP_ALT);
    top_match = (top_eff != '0) && ({1'b0, addr_blk} == top_blk - 1'b1);
    in_legacy      = |seg_match;
    smm_legacy_cpu = (|seg_owned) && !from_pci;
    smm_region     = (|seg_owned) || (smm_en && top_place && top_match);
  end
endmodule

// File: rtl/host_mem_router.sv
module host_mem_router
  import hmr_pkg::*;
#(
  parameter int CEIL_MB      = 192,
  parameter int RESET_TOP_MB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [TOP_W-1:0]  cfg_top_mb,
  input  logic              cfg_gap_en,
  input  logic [GAP_W-1:0]  cfg_gap_base,
  input  logic [1:0]        cfg_gap_size,
  input  logic              cfg_smm_en,
  input  logic [1:0]        cfg_smm_place,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_from_pci,
  output logic              route_dram,
  output logic              route_pci,
  output logic              cacheable,
  output logic              smram_hit
);
  router_cfg_t      cfg_in;
  router_cfg_t      cfg_q;
  logic [TOP_W-1:0] top_eff;
  logic             gap_hit;
  logic             in_legacy;
  logic             smm_region;
  logic             smm_legacy_cpu;
  logic             below_top;
  logic             to_pci;

  always_comb begin
    cfg_in.top_mb    = cfg_top_mb;
    cfg_in.gap_en    = cfg_gap_en;
    cfg_in.gap_base  = cfg_gap_base;
    cfg_in.gap_size  = cfg_gap_size;
    cfg_in.smm_en    = cfg_smm_en;
    cfg_in.smm_place = smm_place_e'(cfg_smm_place);
  end

  hmr_cfg_regs #(.CEIL_MB(CEIL_MB), .RESET_TOP_MB(RESET_TOP_MB)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .cfg_in  (cfg_in),
    .cfg_q   (cfg_q),
    .top_eff (top_eff)
  );

  hmr_gap_decode u_gap (
    .gap_en   (cfg_q.gap_en),
    .gap_base (cfg_q.gap_base),
    .gap_size (cfg_q.gap_size),
    .addr_mb  (acc_addr[ADDR_W-1:MB_SHIFT]),
    .gap_hit  (gap_hit)
  );

  hmr_smram_decode u_smm (
    .smm_en         (cfg_q.smm_en),
    .smm_place      (cfg_q.smm_place),
    .top_eff        (top_eff),
    .addr_blk       (acc_addr[ADDR_W-1:SMM_SHIFT]),
    .from_pci       (acc_from_pci),
    .in_legacy      (in_legacy),
    .smm_region     (smm_region),
    .smm_legacy_cpu (smm_legacy_cpu)
  );

  // Priority: legacy segments, then gap, then top-of-memory compare
  always_comb begin
    below_top  = acc_addr[ADDR_W-1:MB_SHIFT] < MB_IDX_W'(top_eff);
    if (in_legacy) to_pci = !smm_legacy_cpu;
    else           to_pci = gap_hit || !below_top;
    route_pci  = to_pci;
    route_dram = !to_pci;
    cacheable  = !to_pci;
    smram_hit  = !to_pci && smm_region && !acc_from_pci;
  end

  assert_one_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    route_dram != route_pci);
  assert_gap_to_pci_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_hit && !in_legacy) |-> route_pci);
  assert_pci_no_legacy_smram_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_from_pci && in_legacy) |-> (route_pci && !smram_hit));
  assert_hit_needs_dram_R12: assert property (@(posedge clk) disable iff (!rst_n)
    smram_hit |-> (route_dram && cfg_q.smm_en));
  assert_cache_follows_dram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cacheable |-> !route_pci);
endmodule

// File: tb/tb_host_mem_router.sv
module tb_host_mem_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [9:0]  cfg_top_mb = '0;
  logic        cfg_gap_en = 1'b0;
  logic [3:0]  cfg_gap_base = '0;
  logic [1:0]  cfg_gap_size = '0;
  logic        cfg_smm_en = 1'b0;
  logic [1:0]  cfg_smm_place = '0;
  logic [31:0] acc_addr = '0;
  logic        acc_from_pci = 1'b0;
  logic        route_dram, route_pci, cacheable, smram_hit;

  int checks = 0;
  int errors = 0;

  // bench-side view of the committed configuration
  int m_top = 2, m_gap_en = 0, m_gap_base = 0, m_gap_size = 0, m_smm_en = 0, m_place = 0;
  localparam int CEIL = 192;

  always #2.5 clk = ~clk;

  host_mem_router dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_top_mb(cfg_top_mb),
    .cfg_gap_en(cfg_gap_en), .cfg_gap_base(cfg_gap_base), .cfg_gap_size(cfg_gap_size),
    .cfg_smm_en(cfg_smm_en), .cfg_smm_place(cfg_smm_place), .acc_addr(acc_addr),
    .acc_from_pci(acc_from_pci), .route_dram(route_dram), .route_pci(route_pci),
    .cacheable(cacheable), .smram_hit(smram_hit)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s addr=%08h pci=%0d actual=%0d expected=%0d", tag, acc_addr, acc_from_pci, act, exp);
    end
  endtask

  task automatic model(input longint a, input bit pci, output bit e_dram, output bit e_hit,
                       output string tag);
    longint top_b, lo, hi, sz;
    bit in_ab, in_gap, own_ab, top_reg;
    int te;
    te     = (m_top > CEIL) ? CEIL : m_top;
    top_b  = longint'(te) * 1048576;
    in_ab  = (a >= 'hA0000) && (a < 'hC0000);
    sz     = longint'(1) << m_gap_size;
    lo     = longint'((m_gap_base / sz) * sz) * 1048576;
    hi     = lo + sz * 1048576;
    in_gap = (m_gap_en != 0) && (a >= lo) && (a < hi) && (a >= 1048576);
    own_ab = (m_smm_en != 0) && ((m_place == 1 && a >= 'hA0000 && a < 'hB0000) ||
                                 (m_place == 2 && a >= 'hB0000 && a < 'hC0000));
    top_reg = (m_smm_en != 0) && (m_place == 0 || m_place == 3) && (te > 0) &&
              (a >= top_b - 65536) && (a < top_b);
    e_hit = 1'b0;
    if (in_ab) begin
      e_dram = own_ab && !pci;
      e_hit  = e_dram;
      tag = own_ab ? (pci ? "R9" : "R8") : "R10";
    end else if (in_gap) begin
      e_dram = 1'b0; tag = "R5";
    end else begin
      e_dram = (a < top_b);
      e_hit  = e_dram && top_reg && !pci;
      tag = top_reg ? "R7" : ((m_top > CEIL) ? "R4" : "R3");
    end
  endtask

  task automatic probe(input longint a);
    for (int p = 0; p < 2; p++) begin
      bit e_dram, e_hit;
      string tag;
      acc_addr = 32'(a);
      acc_from_pci = p[0];
      #1;
      model(a, p[0], e_dram, e_hit, tag);
      chk(route_dram == e_dram && route_pci == !e_dram, tag, route_dram, e_dram);
      chk(route_dram != route_pci, "R2", route_pci, !route_dram);
      chk(cacheable == e_dram, "R6", cacheable, e_dram);
      chk(smram_hit == e_hit, (m_smm_en == 0) ? "R12" : tag, smram_hit, e_hit);
    end
  endtask

  task automatic load_cfg(input int top, input int gen, input int gb, input int gs,
                          input int sen, input int pl);
    @(negedge clk);
    cfg_top_mb = 10'(top); cfg_gap_en = gen[0]; cfg_gap_base = 4'(gb);
    cfg_gap_size = 2'(gs); cfg_smm_en = sen[0]; cfg_smm_place = 2'(pl);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_top = top; m_gap_en = gen; m_gap_base = gb; m_gap_size = gs; m_smm_en = sen; m_place = pl;
  endtask

  task automatic sweep();
    longint tb_;
    tb_ = longint'((m_top > CEIL) ? CEIL : m_top) * 1048576;
    for (int k = 0; k <= 17; k++) begin
      probe(longint'(k) * 1048576);
      if (k > 0) probe(longint'(k) * 1048576 - 1);
    end
    probe('h9FFFF); probe('hA0000); probe('hAFFFF);
    probe('hB0000); probe('hBFFFF); probe('hC0000);
    if (tb_ > 65537) begin
      probe(tb_ - 65537); probe(tb_ - 65536); probe(tb_ - 1);
    end
    probe(tb_);
    probe(longint'(CEIL) * 1048576 - 1); probe(longint'(CEIL) * 1048576);
    probe('hFFFFFFFF);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset configuration
    acc_from_pci = 1'b0;
    acc_addr = 32'h001FFFFF; #1; chk(route_dram == 1'b1, "R1", route_dram, 1);
    acc_addr = 32'h00200000; #1; chk(route_pci == 1'b1, "R1", route_pci, 1);
    acc_addr = 32'h000A0000; #1; chk(route_pci == 1'b1 && smram_hit == 1'b0, "R1", route_pci, 1);
    sweep();

    // R11: inputs change without cfg_load; committed configuration must persist
    @(negedge clk);
    cfg_top_mb = 10'd64; cfg_gap_en = 1'b1; cfg_gap_base = 4'd1; cfg_smm_en = 1'b1;
    cfg_smm_place = 2'd1;
    repeat (4) @(negedge clk);
    acc_from_pci = 1'b0;
    acc_addr = 32'h00200000; #1; chk(route_pci == 1'b1, "R11", route_pci, 1);
    acc_addr = 32'h00100000; #1; chk(route_dram == 1'b1, "R11", route_dram, 1);
    acc_addr = 32'h000A0000; #1; chk(smram_hit == 1'b0, "R11", smram_hit, 0);
    sweep();

    // Top of memory and ceiling, SMRAM at top
    load_cfg(16, 0, 0, 0, 0, 0);   sweep();
    load_cfg(64, 0, 0, 0, 1, 0);   sweep();
    load_cfg(191, 0, 0, 0, 1, 3);  sweep();
    load_cfg(192, 0, 0, 0, 1, 0);  sweep();
    load_cfg(300, 0, 0, 0, 1, 0);  sweep();
    load_cfg(1023, 0, 0, 0, 0, 0); sweep();
    load_cfg(0, 0, 0, 0, 1, 0);    sweep();

    // Gap: every base and size
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 16; b++) begin
        load_cfg(32, 1, b, s, 0, 0);
        sweep();
      end

    // Gap overlapping top-of-memory SMRAM
    load_cfg(8, 1, 4, 2, 1, 0);    sweep();
    load_cfg(12, 1, 8, 3, 1, 3);   sweep();

    // Legacy segment placements
    for (int pl = 0; pl < 4; pl++) begin
      load_cfg(32, 0, 0, 0, 1, pl); sweep();
      load_cfg(32, 0, 0, 0, 0, pl); sweep();
    end
    load_cfg(4, 1, 2, 1, 1, 2);    sweep();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule